// File: doc/BRIEF.md
# Peripheral Access Filter

This block decides whether one bus access to a protected peripheral may go ahead. The interconnect presents the access itself: the target ID, the secure and privileged attributes, and the compartment ID of the master. The register bank presents the access rules for the addressed peripheral. These are a secure-only bit, a privileged-only bit, a 32-bit compartment-filter word, and the present owner of that peripheral's semaphore.

One cycle after a valid request, the block returns a verdict and a 2-bit reason code. The check runs in a fixed order: security attribute first, then privilege, then compartment. Compartment filtering has two modes. In the static mode a single owner ID is allowed. In the semaphore mode an access is allowed only when its compartment is on a whitelist and currently holds the semaphore.

Target IDs at or above a parameterised limit name bus masters, not peripherals, so they pass without any check. The block does not produce bus error responses and holds no rule storage.

Top module: `periph_access_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid`, `rsp_allow` and `rsp_reason` are all 0.
- R2: `rsp_valid` is asserted exactly one cycle after `req_valid`. In a cycle with no request, `rsp_allow` and `rsp_reason` keep their previous values.
- R3: A non-secure access (`req_secure`=0) to a peripheral with `rule_secure`=1 is denied with reason code 1. This check wins over every other check.
- R4: If R3 does not deny, an unprivileged access (`req_priv`=0) to a peripheral with `rule_priv`=1 is denied with reason code 2.
- R5: When bit 0 of `rule_filter` (filter enable) is 0, an access that passes R3 and R4 is allowed.
- R6: When filtering is enabled and bit 1 of `rule_filter` (semaphore mode) is 0, the access is allowed only if `req_cid` equals the static owner field in bits 6:4.
- R7: In semaphore mode, the access is allowed only if all three hold: bit 16+`req_cid` of `rule_filter` (whitelist in bits 23:16) is set, `sem_busy` is 1, and `sem_owner` equals `req_cid`.
- R8: An access that fails the R6 or R7 condition is denied with reason code 3.
- R9: A `req_id` at or above `PERIPH_LIMIT` is allowed with reason code 0, whatever the attributes and rules are.
- R10: When a response is valid, `rsp_allow` is 1 exactly when `rsp_reason` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_id | input | ID_W | Target peripheral or master ID |
| req_secure | input | 1 | Access is secure |
| req_priv | input | 1 | Access is privileged |
| req_cid | input | CID_W | Compartment ID of the requester |
| rule_secure | input | 1 | Peripheral accepts secure accesses only |
| rule_priv | input | 1 | Peripheral accepts privileged accesses only |
| rule_filter | input | 32 | Compartment-filter word of the peripheral |
| sem_busy | input | 1 | Peripheral semaphore is taken |
| sem_owner | input | CID_W | Compartment holding the semaphore |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_reason | output | 2 | 0 allowed, 1 secure, 2 privilege, 3 compartment |

## Verification
The bench targets accesses that break several rules at once. A design with the priority order wrong would report privilege or compartment instead of secure.

It sets the static owner field to a value that the whitelist bits would allow, and the reverse, so a design that reads the wrong field for the selected mode gives the wrong verdict. It also covers three semaphore cases: taken by a different whitelisted compartment, free, and owned by a compartment that is not whitelisted. Any one of these would be wrongly allowed by a design that checks only the whitelist or only the owner.

IDs exactly at the limit and just below it catch an off-by-one in the bypass decode. Idle cycles catch outputs that do not hold.

// File: rtl/periph_access_filter.sv
module periph_access_filter #(
  parameter int ID_W         = 8,
  parameter int CID_W        = 3,
  parameter int PERIPH_LIMIT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ID_W-1:0]  req_id,
  input  logic             req_secure,
  input  logic             req_priv,
  input  logic [CID_W-1:0] req_cid,
  input  logic             rule_secure,
  input  logic             rule_priv,
  input  logic [31:0]      rule_filter,
  input  logic             sem_busy,
  input  logic [CID_W-1:0] sem_owner,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic [1:0]       rsp_reason
);
  localparam int NCID = 1 << CID_W;
  localparam int SID_LO = 4;
  localparam int WL_LO = 16;
  localparam logic [ID_W-1:0] LIMIT = ID_W'(PERIPH_LIMIT);

  localparam logic [1:0] RSN_OK   = 2'd0;
  localparam logic [1:0] RSN_SEC  = 2'd1;
  localparam logic [1:0] RSN_PRIV = 2'd2;
  localparam logic [1:0] RSN_CID  = 2'd3;

  logic             is_master;
  logic             filt_en, sem_mode;
  logic [CID_W-1:0] static_cid;
  logic [NCID-1:0]  whitelist;
  logic             cid_ok;
  logic [1:0]       reason_d;

  assign is_master  = req_id >= LIMIT;
  assign filt_en    = rule_filter[0];
  assign sem_mode   = rule_filter[1];
  assign static_cid = rule_filter[SID_LO +: CID_W];
  assign whitelist  = rule_filter[WL_LO +: NCID];

  assign cid_ok = !filt_en ? 1'b1 :
                  sem_mode ? (whitelist[req_cid] && sem_busy && sem_owner == req_cid)
                           : (static_cid == req_cid);

  always_comb begin
    if (is_master)                      reason_d = RSN_OK;
    else if (!req_secure && rule_secure) reason_d = RSN_SEC;
    else if (!req_priv && rule_priv)     reason_d = RSN_PRIV;
    else if (!cid_ok)                    reason_d = RSN_CID;
    else                                 reason_d = RSN_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_reason <= RSN_OK;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow  <= reason_d == RSN_OK;
        rsp_reason <= reason_d;
      end
    end
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rsp_valid == $past(req_valid));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(req_valid)) |-> ($stable(rsp_allow) && $stable(rsp_reason)));

  // R10
  allow_matches_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_allow == (rsp_reason == RSN_OK)));

  // R3
  secure_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && !$past(is_master) && !$past(req_secure) && $past(rule_secure))
      |-> rsp_reason == RSN_SEC);

  // R9
  master_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && $past(is_master)) |-> rsp_allow);

  // R7
  sem_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && !$past(is_master) && $past(filt_en) && $past(sem_mode)
      && !$past(sem_busy)) |-> !rsp_allow);
endmodule

// File: tb/periph_access_filter_test.sv
module periph_access_filter_test;
  localparam int ID_W = 8;
  localparam int CID_W = 3;
  localparam int LIMIT = 128;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_secure, req_priv, rule_secure, rule_priv, sem_busy;
  logic [ID_W-1:0] req_id;
  logic [CID_W-1:0] req_cid, sem_owner;
  logic [31:0] rule_filter;
  logic rsp_valid, rsp_allow;
  logic [1:0] rsp_reason;

  periph_access_filter #(.ID_W(ID_W), .CID_W(CID_W), .PERIPH_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_secure(req_secure), .req_priv(req_priv), .req_cid(req_cid),
    .rule_secure(rule_secure), .rule_priv(rule_priv), .rule_filter(rule_filter),
    .sem_busy(sem_busy), .sem_owner(sem_owner),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_reason(rsp_reason));

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic exp_allow = 0;
  logic [1:0] exp_reason = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(int id, bit s, bit p, int cid, bit rs, bit rp,
                               logic [31:0] w, bit busy, int own, output string tag);
    if (id >= LIMIT) begin tag = "R9"; return 0; end
    if (!s && rs) begin tag = "R3"; return 1; end
    if (!p && rp) begin tag = "R4"; return 2; end
    if (w[0] == 0) begin tag = "R5"; return 0; end
    if (w[1] == 0) begin
      tag = "R6";
      if (cid == int'(w[6:4])) return 0;
      tag = "R6/R8"; return 3;
    end
    tag = "R7";
    if (w[16 + cid] && busy && own == cid) return 0;
    tag = "R7/R8"; return 3;
  endfunction

  task automatic step(bit v, int id, bit s, bit p, int cid, bit rs, bit rp,
                      logic [31:0] w, bit busy, int own);
    string tag;
    int r;
    req_valid = v; req_id = ID_W'(id); req_secure = s; req_priv = p;
    req_cid = CID_W'(cid); rule_secure = rs; rule_priv = rp; rule_filter = w;
    sem_busy = busy; sem_owner = CID_W'(own);
    tag = "R2 hold";
    if (v) begin
      r = model(id, s, p, cid, rs, rp, w, busy, own, tag);
      exp_reason = 2'(r);
      exp_allow = (r == 0);
    end
    @(negedge clk);
    check("R2 valid", int'(rsp_valid), int'(v));
    check({tag, " reason"}, int'(rsp_reason), int'(exp_reason));
    check({tag, " allow R10"}, int'(rsp_allow), int'(exp_allow));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 1; req_id = 0; req_secure = 0; req_priv = 0; req_cid = 0;
    rule_secure = 1; rule_priv = 1; rule_filter = 32'h1; sem_busy = 0; sem_owner = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", int'(rsp_valid), 0);
    check("R1 allow", int'(rsp_allow), 0);
    check("R1 reason", int'(rsp_reason), 0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1 valid after", int'(rsp_valid), 0);
    check("R1 reason after", int'(rsp_reason), 0);

    // R3: all violations at once, secure wins
    step(1, 5, 0, 0, 2, 1, 1, 32'h0000_0051, 0, 0);
    // R2: idle holds reason 1
    step(0, 5, 1, 1, 5, 0, 0, 32'h0, 0, 0);
    // R4: privilege beats compartment
    step(1, 5, 1, 0, 2, 1, 1, 32'h0000_0051, 0, 0);
    // R5: filter off
    step(1, 7, 0, 0, 6, 0, 0, 32'h00FF_0072, 0, 0);
    // R6: static match, whitelist irrelevant
    step(1, 7, 1, 1, 5, 1, 1, 32'h0000_0051, 0, 0);
    // R6/R8: static mismatch although whitelisted
    step(1, 7, 1, 1, 2, 1, 1, 32'h0004_0051, 1, 2);
    // R7: whitelisted and owner, static field differs
    step(1, 9, 1, 1, 2, 0, 0, 32'h0004_0073, 1, 2);
    // R7/R8: other whitelisted owner
    step(1, 9, 1, 1, 2, 0, 0, 32'h000C_0023, 1, 3);
    // R7/R8: semaphore free
    step(1, 9, 1, 1, 2, 0, 0, 32'h0004_0023, 0, 2);
    // R7/R8: owner but not whitelisted
    step(1, 9, 1, 1, 2, 0, 0, 32'h0008_0023, 1, 2);
    // R9: limit boundary
    step(1, LIMIT, 0, 0, 1, 1, 1, 32'h0000_0051, 0, 0);
    step(1, LIMIT - 1, 0, 0, 1, 1, 1, 32'h0000_0051, 0, 0);
    step(1, 255, 0, 0, 1, 1, 1, 32'h0000_0003, 0, 0);
    step(0, 3, 0, 0, 0, 0, 0, 32'h0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] w;
      w = $urandom;
      w[3:2] = 0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 255), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, w, $urandom_range(0, 1), $urandom_range(0, 7));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule